// File: doc/BRIEF.md
# Counter-Timed Ping-Pong Bank Controller

This block runs two equal single-port memory banks as a double buffer inside one clock domain. A free-running counter, clocked by the system clock, produces an epoch flag from its top bit. The flag decides which bank takes writes and which bank answers reads. The two roles trade places every half counter period. A producer writes a frame into one bank while a consumer reads the previous frame from the other bank, and the two never touch the same bank in the same cycle.

The epoch is an ordinary register output in the system clock domain. It drives no clock pin and no clock buffer. It steers the write enables, the bank addresses and the read-data multiplexer. A one-cycle swap pulse marks each handoff. The banks are plain inferred arrays with a registered read port, so the synthesis tool can map them to block RAM.

Top module: `pp_bank_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the counter, the epoch and the swap pulse to 0. In the first cycle after reset the epoch is 0, so bank B is the write bank.
- R2: The counter is CNT_W bits wide (default 16) and counts up by one every cycle. In cycle n after reset, the epoch equals bit CNT_W-1 of n, so each phase lasts 2^(CNT_W-1) cycles.
- R3: swap_o is high only in the first cycle in which the epoch holds a new value, and it is high in every such cycle. It is low in the first cycle after reset.
- R4: While the epoch is 0, a valid write stores wr_data_i at wr_addr_i in bank B, and reads are served from bank A.
- R5: While the epoch is 1, a valid write stores wr_data_i at wr_addr_i in bank A, and reads are served from bank B.
- R6: A bank is written only when wr_valid_i is high and that bank is the current write bank. Both banks are never written in the same cycle, and a cycle with wr_valid_i low leaves both banks unchanged.
- R7: rd_data_o shows, one cycle after rd_addr_i is presented, the word at that address in the bank that was the read bank in the address cycle. This also holds when the epoch flips between the address cycle and the data cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid_i | input | 1 | Write request for this cycle |
| wr_addr_i | input | $clog2(DEPTH) | Write address in the current write bank |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | $clog2(DEPTH) | Read address in the current read bank |
| rd_data_o | output | DW | Read data, one cycle after the address |
| epoch_o | output | 1 | Epoch flag: 1 means write A and read B, 0 means write B and read A |
| swap_o | output | 1 | Pulses high for one cycle after each epoch change |

## Verification
The checker's phase counter and its change detector assume that reset is held across at least one rising edge before any check matters, and that wr_valid_i is never unknown. The bench holds reset for several edges, drives every input at a known level from the start, and asserts reset a second time mid-run so that a phase is cut short. Read data is compared only at addresses the bench model has already written, because bank contents before the first write are undefined.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // Bank indices used for the generate loop and the steering.
  localparam int unsigned BANK_A = 0;
  localparam int unsigned BANK_B = 1;
  localparam int unsigned NUM_BANKS = 2;

  // Bank written in a given epoch: epoch 1 writes A, epoch 0 writes B.
  function automatic logic is_write_bank(input int unsigned bank, input logic epoch);
    return (bank == BANK_A) ? epoch : ~epoch;
  endfunction
endpackage

// File: rtl/pp_epoch_timer.sv
module pp_epoch_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  output logic epoch_o,
  output logic swap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             epoch_q;
  logic             swap_q;
  logic             epoch_nxt;

  always_comb begin
    cnt_nxt   = cnt_q + 1'b1;
    epoch_nxt = cnt_nxt[CNT_W-1];
  end

  // The epoch is a plain data register in the clk domain.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      epoch_q <= 1'b0;
      swap_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      epoch_q <= epoch_nxt;
      swap_q  <= epoch_nxt ^ epoch_q;
    end
  end

  assign epoch_o = epoch_q;
  assign swap_o  = swap_q;
endmodule

// File: rtl/pp_bank.sv
module pp_bank #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] mem [DEPTH];

  // Single-port, read-first, registered output.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= din;
    end
    dout <= mem[addr];
  end
endmodule

// File: rtl/pp_bank_ctrl.sv
module pp_bank_ctrl
  import pp_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          epoch_o,
  output logic          swap_o
);
  logic                 epoch;
  logic                 rd_sel_q;
  logic [NUM_BANKS-1:0] bank_we;
  logic [DW-1:0]        bank_dout [NUM_BANKS];

  pp_epoch_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .epoch_o (epoch),
    .swap_o  (swap_o)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic          wr_role;
    logic [AW-1:0] addr;

    always_comb begin
      wr_role    = is_write_bank(g, epoch);
      bank_we[g] = wr_valid_i & wr_role;
      addr       = wr_role ? wr_addr_i : rd_addr_i;
    end

    pp_bank #(
      .DEPTH (DEPTH),
      .DW    (DW)
    ) u_bank (
      .clk  (clk),
      .we   (bank_we[g]),
      .addr (addr),
      .din  (wr_data_i),
      .dout (bank_dout[g])
    );
  end

  // Read bank is captured with the address so a swap cannot redirect
  // a read that is already in flight.
  always_ff @(posedge clk) begin
    rd_sel_q <= epoch;
  end

  assign rd_data_o = rd_sel_q ? bank_dout[BANK_B] : bank_dout[BANK_A];
  assign epoch_o   = epoch;
endmodule

// File: rtl/pp_bank_ctrl_chk.sv
module pp_bank_ctrl_chk #(
  parameter int unsigned PHASE = 32768,
  localparam int unsigned RW   = $clog2(PHASE) + 2
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_valid,
  input logic [1:0] we,
  input logic       epoch,
  input logic       swap
);
  logic          prev_q;
  logic [RW-1:0] run_q;
  logic          changed;

  assign changed = epoch != prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= epoch;
      run_q  <= changed ? RW'(1) : run_q + 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!epoch && !swap)); // R1
  AST_PHASE_LENGTH: assert property (@(posedge clk) disable iff (rst)
    changed |-> run_q == RW'(PHASE)); // R2
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_q <= RW'(PHASE)); // R2
  AST_SWAP_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    swap |-> changed); // R3
  AST_CHANGE_GIVES_SWAP: assert property (@(posedge clk) disable iff (rst)
    changed |-> swap); // R3
  AST_B_WRITTEN_IN_EPOCH0: assert property (@(posedge clk) disable iff (rst)
    we[1] |-> !epoch); // R4
  AST_A_WRITTEN_IN_EPOCH1: assert property (@(posedge clk) disable iff (rst)
    we[0] |-> epoch); // R5
  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $countones(we) <= 1); // R6
  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (we != 2'b00) |-> wr_valid); // R6
endmodule

bind pp_bank_ctrl pp_bank_ctrl_chk #(
  .PHASE (1 << (CNT_W - 1))
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid_i),
  .we       (bank_we),
  .epoch    (epoch_o),
  .swap     (swap_o)
);

// File: tb/test_pp_bank_ctrl.sv
`timescale 1ns/1ps
module test_pp_bank_ctrl;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int CNT_W = 5;
  localparam int AW    = $clog2(DEPTH);
  localparam int PHASE = 1 << (CNT_W - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          epoch_o;
  logic          swap_o;

  always #2.5 clk = ~clk;

  pp_bank_ctrl #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) i_pp_bank_ctrl (
    .clk(clk), .rst(rst), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .epoch_o(epoch_o), .swap_o(swap_o)
  );

  int compared = 0;
  int mismatched = 0;

  // Bench model: index 0 is bank A, index 1 is bank B.
  logic [DW-1:0] mdl     [2][DEPTH];
  bit            known   [2][DEPTH];
  bit            skipped [2][DEPTH];
  logic [DW-1:0] exp_rd;
  bit            exp_ok = 1'b0;
  string         exp_tag;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wr_valid_i = 1'b0;
    exp_ok = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 epoch in reset", {31'd0, epoch_o}, 32'd0);
    check("R1 swap in reset", {31'd0, swap_o}, 32'd0);
    rst = 1'b0;
  endtask

  // Entered at the falling edge of cycle 0 after reset.
  task automatic run_cycles(int count);
    for (int n = 0; n < count; n++) begin
      int  e  = (n >> (CNT_W - 1)) & 1;
      int  rb = e;
      int  wb = 1 - e;
      bit  v  = (n % 5) != 3;
      int  a  = (n * 5 + 1) % DEPTH;
      int  d  = (n * 37 + 11 + e * 64) & 255;
      int  ra = (n * 3) % DEPTH;
      check(n == 0 ? "R1 epoch after reset" : "R2 epoch", {31'd0, epoch_o}, e);
      check("R3 swap", {31'd0, swap_o}, (n > 0 && n % PHASE == 0) ? 1 : 0);
      if (exp_ok) check(exp_tag, rd_data_o, exp_rd);
      wr_valid_i = v;
      wr_addr_i  = AW'(a);
      wr_data_i  = DW'(d);
      rd_addr_i  = AW'(ra);
      exp_ok = known[rb][ra];
      exp_rd = mdl[rb][ra];
      if (n % PHASE == PHASE - 1) exp_tag = "R7 read across swap";
      else if (skipped[rb][ra])   exp_tag = "R6 word kept after invalid write";
      else if (e == 1)            exp_tag = "R5 read bank B";
      else                        exp_tag = "R4 read bank A";
      if (v) begin
        mdl[wb][a]     = DW'(d);
        known[wb][a]   = 1'b1;
        skipped[wb][a] = 1'b0;
      end else if (known[wb][a]) begin
        skipped[wb][a] = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) begin
        known[b][i] = 1'b0;
        skipped[b][i] = 1'b0;
        mdl[b][i] = '0;
      end
    do_reset();
    run_cycles(PHASE * 6 + 5);
    do_reset();
    run_cycles(PHASE * 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule